// File: doc/BRIEF.md
# Dual-Rail Master-Slave Precharge Register

This block is a pipeline register for logic in which every bit travels on two wires, a true rail and a false rail. A bit is valid when exactly one of its rails is 1. The bit is in the precharged state when both rails are 0. The clock runs at twice the data rate. One clock cycle is an evaluation cycle and the next is a precharge cycle, and this pattern repeats.

Each bit is held in four ordinary flip-flops: a master and a slave on the true rail, and a master and a slave on the false rail. The register stores both kinds of values, the evaluated data and the all-zero precharge pattern. Because of this, it launches the precharge zeros into the next stage by itself, and the downstream AND/OR-only cone needs no precharge net.

Only the module inputs need a precharge operator. An optional input gate forces the inputs to zero during precharge cycles. A phase output tells neighbouring logic which kind of cycle is in progress.

Top module: `drr_ms_reg`

## Requirements
- R1: While `rst` is 1 at a rising edge, the next cycle shows `dout_t` and `dout_f` all zero and `phase_eval` at 0 (precharge), whatever the inputs carry.
- R2: After reset is released, `phase_eval` is 0 in the first cycle and then toggles on every clock edge. 1 means evaluation and 0 means precharge.
- R3: With `GATE_INPUT`=1, values driven on `din_t`/`din_f` during a precharge cycle never reach the outputs.
- R4: In an evaluation cycle, `dout_t`/`dout_f` equal the inputs that were present in the evaluation cycle two clocks earlier, which is one data period of latency.
- R5: In every precharge cycle both output rails of every bit are 0, so the stored zeros start the precharge wave downstream.
- R6: A valid input code in an evaluation cycle (true rail = data, false rail = its complement) gives exactly one 1 per bit at the output two clocks later. A dual-rail AND/OR cone fed from the output then matches the single-ended result.
- R7: Each output rail changes at most once per clock cycle in the allowed direction. It rises only when entering an evaluation cycle and falls only when entering a precharge cycle.
- R8: Codes sampled in evaluation cycles that are not valid (both rails 1 or both 0) pass through unchanged. They are not corrected or filtered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the data rate |
| rst | input | 1 | Synchronous active-high reset |
| din_t | input | WIDTH | True rails of the incoming dual-rail bus |
| din_f | input | WIDTH | False rails of the incoming dual-rail bus |
| dout_t | output | WIDTH | True rails launched into the next stage |
| dout_f | output | WIDTH | False rails launched into the next stage |
| phase_eval | output | 1 | 1 in evaluation cycles, 0 in precharge cycles |

## Verification
A master or slave that holds a stale value shows at the outputs within two clocks. It appears either as a nonzero rail in a precharge cycle or as an evaluated code that differs from the one sent one data period earlier. A phase flop that is out of step turns every later cycle into a mismatch, on the phase output and on the gated data. Corrupted one-hot codes are exposed through the bench's dual-rail cone, which compares its AND and XOR results against single-ended arithmetic in each evaluation cycle.

// File: rtl/drr_pkg.sv
package drr_pkg;

   typedef enum logic {
      PH_PRE  = 1'b0,
      PH_EVAL = 1'b1
   } drr_phase_e;

   localparam int unsigned DRR_RAILS  = 2;
   localparam int unsigned DRR_TRUE   = 0;
   localparam int unsigned DRR_FALSE  = 1;

endpackage

// File: rtl/drr_phase_gen.sv
module drr_phase_gen
   import drr_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   output drr_phase_e phase
);

   always_ff @(posedge clk) begin
      if (rst) phase <= PH_PRE;
      else     phase <= (phase == PH_PRE) ? PH_EVAL : PH_PRE;
   end

   AST_PHASE_TOGGLES: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (phase != $past(phase)))
      else $error("phase did not alternate"); // R2

endmodule

// File: rtl/drr_pre_gate.sv
module drr_pre_gate
   import drr_pkg::*;
#(
   parameter int unsigned WIDTH = 8
)(
   input  drr_phase_e       phase,
   input  logic [WIDTH-1:0] in_t,
   input  logic [WIDTH-1:0] in_f,
   output logic [WIDTH-1:0] out_t,
   output logic [WIDTH-1:0] out_f
);

   logic [WIDTH-1:0] open_mask;

   always_comb begin
      open_mask = {WIDTH{phase == PH_EVAL}};
      out_t     = in_t & open_mask;
      out_f     = in_f & open_mask;
   end

endmodule

// File: rtl/drr_rail_ms.sv
module drr_rail_ms #(
   parameter int unsigned WIDTH = 8
)(
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] master_q;
   logic [WIDTH-1:0] slave_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         master_q <= '0;
         slave_q  <= '0;
      end else begin
         master_q <= d;
         slave_q  <= master_q;
      end
   end

   assign q = slave_q;

endmodule

// File: rtl/drr_ms_reg.sv
module drr_ms_reg
   import drr_pkg::*;
#(
   parameter int unsigned WIDTH      = 8,
   parameter bit          GATE_INPUT = 1'b1
)(
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din_t,
   input  logic [WIDTH-1:0] din_f,
   output logic [WIDTH-1:0] dout_t,
   output logic [WIDTH-1:0] dout_f,
   output logic             phase_eval
);

   localparam int unsigned RAILS = DRR_RAILS;

   initial begin
      assert (WIDTH >= 1) else $error("WIDTH must be at least 1");
   end

   drr_phase_e       phase;
   logic [WIDTH-1:0] gated_t;
   logic [WIDTH-1:0] gated_f;
   logic [WIDTH-1:0] rail_in  [RAILS];
   logic [WIDTH-1:0] rail_out [RAILS];

   drr_phase_gen u_phase (
      .clk   (clk),
      .rst   (rst),
      .phase (phase)
   );

   generate
      if (GATE_INPUT) begin : g_gate
         drr_pre_gate #(.WIDTH(WIDTH)) u_gate (
            .phase (phase),
            .in_t  (din_t),
            .in_f  (din_f),
            .out_t (gated_t),
            .out_f (gated_f)
         );
      end else begin : g_pass
         assign gated_t = din_t;
         assign gated_f = din_f;
      end
   endgenerate

   assign rail_in[DRR_TRUE]  = gated_t;
   assign rail_in[DRR_FALSE] = gated_f;

   generate
      for (genvar r = 0; r < RAILS; r++) begin : g_rail
         drr_rail_ms #(.WIDTH(WIDTH)) u_rail (
            .clk (clk),
            .rst (rst),
            .d   (rail_in[r]),
            .q   (rail_out[r])
         );
      end
   endgenerate

   assign dout_t     = rail_out[DRR_TRUE];
   assign dout_f     = rail_out[DRR_FALSE];
   assign phase_eval = (phase == PH_EVAL);

   logic code_ok_in;
   logic code_ok_out;
   assign code_ok_in  = ((gated_t ^ gated_f) == {WIDTH{1'b1}}) && ((gated_t & gated_f) == '0);
   assign code_ok_out = ((dout_t ^ dout_f) == {WIDTH{1'b1}}) && ((dout_t & dout_f) == '0);

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (dout_t == '0 && dout_f == '0 && !phase_eval))
      else $error("reset did not clear the register"); // R1

   AST_ONEHOT_KEPT: assert property (@(posedge clk) disable iff (rst)
      (phase_eval && !$past(rst) && !$past(rst, 2) && $past(code_ok_in, 2)) |-> code_ok_out)
      else $error("valid code lost its one-hot form"); // R6

   generate
      if (GATE_INPUT) begin : g_gate_chk
         AST_PRECHARGE_ZERO: assert property (@(posedge clk) disable iff (rst)
            !phase_eval |-> (dout_t == '0 && dout_f == '0))
            else $error("rail high during precharge"); // R5

         AST_RISE_ON_EVAL: assert property (@(posedge clk) disable iff (rst)
            (((dout_t & ~$past(dout_t)) | (dout_f & ~$past(dout_f))) != '0) |-> phase_eval)
            else $error("rail rose outside evaluation"); // R7
      end
   endgenerate

endmodule

// File: tb/sim_drr_ms_reg.sv
module sim_drr_ms_reg;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] din_t = '0;
   logic [W-1:0] din_f = '0;
   logic [W-1:0] dout_t;
   logic [W-1:0] dout_f;
   logic         phase_eval;

   int checks = 0;
   int errors = 0;

   logic [W-1:0] h1t, h1f, h2t, h2f, pt, pf;
   logic         exp_eval;

   always #5 clk = ~clk;

   drr_ms_reg #(.WIDTH(W), .GATE_INPUT(1'b1)) u0 (
      .clk        (clk),
      .rst        (rst),
      .din_t      (din_t),
      .din_f      (din_f),
      .dout_t     (dout_t),
      .dout_f     (dout_f),
      .phase_eval (phase_eval)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; din_t = '1; din_f = '1;
      repeat (3) @(negedge clk);
      chk("R1 true rails", dout_t, '0);
      chk("R1 false rails", dout_f, '0);
      chk("R1 phase", W'(phase_eval), '0);
      rst = 1'b0; din_t = '0; din_f = '0;
      h1t = '0; h1f = '0; h2t = '0; h2f = '0; pt = '0; pf = '0;
      exp_eval = 1'b1;
   endtask

   // one clock: check this cycle's outputs, then drive this cycle's inputs
   task automatic tick(input logic [W-1:0] t, input logic [W-1:0] f, input string dtag);
      logic ok2, ref_and, ref_xor, ct, cf, xt, xf;
      @(negedge clk);
      chk("R2 phase", W'(phase_eval), W'(exp_eval));
      if (exp_eval) begin
         chk(dtag, dout_t, h2t);
         chk(dtag, dout_f, h2f);
         ok2 = ((h2t ^ h2f) == '1) && ((h2t & h2f) == '0);
         if (ok2) begin
            chk("R6 one-hot", dout_t ^ dout_f, '1);
            ct = dout_t[0] & dout_t[1];
            cf = dout_f[0] | dout_f[1];
            xt = (dout_t[2] & dout_f[3]) | (dout_f[2] & dout_t[3]);
            xf = (dout_t[2] & dout_t[3]) | (dout_f[2] & dout_f[3]);
            ref_and = h2t[0] & h2t[1];
            ref_xor = h2t[2] ^ h2t[3];
            chk("R6 cone and", {ct, cf}, {ref_and, ~ref_and});
            chk("R6 cone xor", {xt, xf}, {ref_xor, ~ref_xor});
         end
      end else begin
         chk("R5 precharge true", dout_t, '0);
         chk("R5 precharge false", dout_f, '0);
      end
      chk("R7 true rail", exp_eval ? (pt & ~dout_t) : (dout_t & ~pt), '0);
      chk("R7 false rail", exp_eval ? (pf & ~dout_f) : (dout_f & ~pf), '0);
      pt = dout_t; pf = dout_f;
      din_t = t; din_f = f;
      h2t = h1t; h2f = h1f; h1t = t; h1f = f;
      exp_eval = ~exp_eval;
   endtask

   task automatic send(input logic [W-1:0] et, input logic [W-1:0] ef,
                       input logic [W-1:0] pt_in, input logic [W-1:0] pf_in, input string dtag);
      tick(et, ef, dtag);
      tick(pt_in, pf_in, dtag);
   endtask

   task automatic drain();
      for (int i = 0; i < 3; i++) send('0, '0, '0, '0, "R4 drain");
   endtask

   task automatic t_valid_stream();
      for (int i = 0; i < 24; i++) begin
         logic [W-1:0] v;
         v = W'($urandom);
         send(v, ~v, '0, '0, "R4 stream");
      end
      drain();
   endtask

   task automatic t_corner_values();
      send('0, '1, '0, '0, "R4 all zero data");
      send('1, '0, '0, '0, "R4 all one data");
      send(8'hA5, 8'h5A, '0, '0, "R4 pattern");
      send(8'h5A, 8'hA5, '0, '0, "R4 pattern flip");
      drain();
   endtask

   task automatic t_precharge_noise();
      for (int i = 0; i < 12; i++) begin
         logic [W-1:0] v;
         v = W'($urandom);
         send(v, ~v, W'($urandom), W'($urandom), "R3 noisy precharge");
      end
      drain();
   endtask

   task automatic t_invalid_codes();
      send('1, '1, '0, '0, "R8 both rails high");
      send('0, '0, '0, '0, "R8 both rails low");
      send(8'hF0, 8'h3C, '0, '0, "R8 mixed code");
      drain();
   endtask

   task automatic t_midstream_reset();
      for (int i = 0; i < 4; i++) begin
         logic [W-1:0] v;
         v = W'($urandom);
         send(v, ~v, '0, '0, "R4 before reset");
      end
      do_reset();
      send(8'h3C, 8'hC3, '0, '0, "R4 after reset");
      drain();
   endtask

   initial begin
      exp_eval = 1'b1;
      do_reset();
      t_valid_stream();
      t_corner_values();
      t_precharge_noise();
      t_invalid_codes();
      t_midstream_reset();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule